// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

This block keeps the pending-event flags of a 16-bit up-counting timer that has two capture/compare channels and a trigger input. The counter, the prescaler and the capture latches sit elsewhere. This block only sees their results: the current count, the reload limit, each channel's stored compare/capture value, capture strobes, the overflow event, and the trigger or gate events from the slave controller. From these it sets one bit per event in a 16-bit status word.

Software reads the status word over a small register bus. It clears a flag by writing 0 to that bit. A bus read of a channel's value register also clears that channel's flag while the channel is in capture mode. A channel that captures again before its flag has been cleared records an overcapture. An interrupt request is raised while any enabled flag is pending.

Gated slave mode uses a two-state machine. The state `GATE_HALTED` moves to `GATE_RUNNING` on a start event, and `GATE_RUNNING` moves back to `GATE_HALTED` on a stop event. Each of these two transitions raises the trigger flag. A start event while running and a stop event while halted cause no transition.

Top module: `tsf_status_flags`

## Requirements
- R1: After reset the status word reads 0x0000. Only bits 0, 1, 2, 6, 9 and 10 can ever read 1. All other bits read 0, even after a write of 0xFFFF.
- R2: A status write (bus_sel = 0) clears each flag whose write-data bit is 0 and leaves each flag whose bit is 1 unchanged.
- R3: A channel in compare mode (ch_capture bit = 0) whose value equals the count sets its flag on the next clock edge. Channel 0 uses bit 1 and channel 1 uses bit 2.
- R4: In compare mode, an overflow pulse sets a channel's flag when that channel's value is greater than the reload value. The same pulse does not set the flag when the value is at or below the reload value.
- R5: A channel in capture mode (ch_capture bit = 1) sets its flag on its cap_edge strobe and ignores count matches. A capture strobe to a channel in compare mode is ignored.
- R6: A bus read with bus_sel = 1 (channel 0) or bus_sel = 2 (channel 1) returns that channel's value. The read clears the channel's flag in capture mode and leaves the flag unchanged in compare mode.
- R7: A capture strobe that arrives while the channel's flag is already set raises the overcapture flag: bit 9 for channel 0, bit 10 for channel 1. This never happens in compare mode.
- R8: When a capture strobe and a read of the same channel's value occur in the same cycle, the flag stays set and no overcapture is recorded.
- R9: With slave_en = 1 and gated_mode = 0, a trig_edge pulse sets bit 6. With slave_en = 0 the pulse is ignored.
- R10: With slave_en = 1 and gated_mode = 1, trig_edge is ignored. Bit 6 is set on a start event taken from `GATE_HALTED` and on a stop event taken from `GATE_RUNNING`. A repeated start or a stop while halted does nothing.
- R11: An overflow pulse sets the update flag at bit 0.
- R12: When a hardware event and a software clear of the same bit occur in one cycle, the bit ends at 1.
- R13: irq is 1 exactly when some status bit and the same bit of irq_en are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | 16 | Current counter value |
| reload_val | input | 16 | Auto-reload limit |
| cmp_val | input | 2x16 | Per-channel compare/capture value, index = channel |
| ch_capture | input | 2 | Per-channel mode: 1 = input capture, 0 = output compare |
| cap_edge | input | 2 | Per-channel capture strobe (qualified edge) |
| ovf | input | 1 | Counter wrap pulse (reload value to zero) |
| slave_en | input | 1 | Slave controller enabled |
| gated_mode | input | 1 | Slave controller in gated mode |
| trig_edge | input | 1 | Active trigger edge pulse |
| gate_start | input | 1 | Gate-open event (gated mode) |
| gate_stop | input | 1 | Gate-close event (gated mode) |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 status, 1 channel 0 value, 2 channel 1 value |
| bus_wdata | input | 16 | Write data (0 clears a flag) |
| bus_rdata | output | 16 | Read data for the selected register |
| irq_en | input | 16 | Per-bit interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the cycles where two causes meet on one bit. In the first, a capture arrives together with a read of its value register. A design that applies the read-clear last would lose the capture, and one that tests the old flag alone would record a false overcapture. In the second, overflow coincides with a write-0 clear, and a design where clear wins drops the update event. The bench also sets a compare value above the reload value to catch a design that never flags such a channel, or flags every channel on overflow. It sends redundant gate start and stop events to expose a design that raises the trigger flag on every gate event instead of on real transitions.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam int STAT_W   = 16;
    localparam int UPD_BIT  = 0;
    localparam int CH_BASE  = 1;
    localparam int TRG_BIT  = 6;
    localparam int OVC_BASE = 9;

    typedef enum logic {
        GATE_HALTED  = 1'b0,
        GATE_RUNNING = 1'b1
    } gate_state_t;

    function automatic logic [STAT_W-1:0] flag_mask(input int n_ch);
        logic [STAT_W-1:0] m;
        m = '0;
        m[UPD_BIT] = 1'b1;
        m[TRG_BIT] = 1'b1;
        for (int i = 0; i < n_ch; i++) begin
            m[CH_BASE + i]  = 1'b1;
            m[OVC_BASE + i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/tsf_chan.sv
module tsf_chan #(
    parameter int CNT_W = 16
) (
    input  logic             capture_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cap_edge,
    input  logic             ovf,
    input  logic             cap_read,
    input  logic             flag_now,
    output logic             set_flag,
    output logic             set_ovc,
    output logic             clr_flag
);

    logic cmp_hit;

    always_comb begin
        cmp_hit  = (cnt == cmp_val) || (ovf && (cmp_val > reload_val));
        set_flag = capture_mode ? cap_edge : cmp_hit;
        // a read in the same cycle consumes the old capture, so no overrun
        set_ovc  = capture_mode && cap_edge && flag_now && !cap_read;
        clr_flag = capture_mode && cap_read;
    end

endmodule

// File: rtl/tsf_gate_fsm.sv
module tsf_gate_fsm
    import tsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic start_evt,
    input  logic stop_evt,
    output logic trig_pulse
);

    gate_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (active) begin
            unique case (state_q)
                GATE_HALTED:  if (start_evt) state_d = GATE_RUNNING;
                GATE_RUNNING: if (stop_evt)  state_d = GATE_HALTED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        trig_pulse = 1'b0;
        if (active) begin
            unique case (state_q)
                GATE_HALTED:  trig_pulse = start_evt;
                GATE_RUNNING: trig_pulse = stop_evt;
            endcase
        end
    end

endmodule

// File: rtl/tsf_bus.sv
module tsf_bus
    import tsf_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 2
) (
    input  logic                         bus_rd,
    input  logic                         bus_wr,
    input  logic [SEL_W-1:0]             bus_sel,
    input  logic [STAT_W-1:0]            status,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_val,
    output logic                         stat_wr,
    output logic [NUM_CH-1:0]            cap_read,
    output logic [STAT_W-1:0]            rdata
);

    localparam logic [SEL_W-1:0] SEL_STATUS = '0;

    assign stat_wr = bus_wr && (bus_sel == SEL_STATUS);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_rd
        assign cap_read[g] = bus_rd && (bus_sel == SEL_W'(g + 1));
    end

    always_comb begin
        rdata = '0;
        if (bus_sel == SEL_STATUS) rdata = status;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_sel == SEL_W'(i + 1)) rdata = STAT_W'(cmp_val[i]);
        end
    end

endmodule

// File: rtl/tsf_status_flags.sv
module tsf_status_flags
    import tsf_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int SEL_W  = $clog2(NUM_CH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             cnt,
    input  logic [CNT_W-1:0]             reload_val,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_val,
    input  logic [NUM_CH-1:0]            ch_capture,
    input  logic [NUM_CH-1:0]            cap_edge,
    input  logic                         ovf,
    input  logic                         slave_en,
    input  logic                         gated_mode,
    input  logic                         trig_edge,
    input  logic                         gate_start,
    input  logic                         gate_stop,
    input  logic                         bus_rd,
    input  logic                         bus_wr,
    input  logic [SEL_W-1:0]             bus_sel,
    input  logic [STAT_W-1:0]            bus_wdata,
    output logic [STAT_W-1:0]            bus_rdata,
    input  logic [STAT_W-1:0]            irq_en,
    output logic                         irq
);

    localparam logic [STAT_W-1:0] FLAG_MASK = flag_mask(NUM_CH);

    logic [STAT_W-1:0] status_q, status_d;
    logic [STAT_W-1:0] set_word, clr_word, keep_word;
    logic [NUM_CH-1:0] ch_set, ch_ovc, ch_clr, cap_read;
    logic              stat_wr, gate_trig, trig_set;

    tsf_bus #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) bus_i (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_sel  (bus_sel),
        .status   (status_q),
        .cmp_val  (cmp_val),
        .stat_wr  (stat_wr),
        .cap_read (cap_read),
        .rdata    (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tsf_chan #(.CNT_W(CNT_W)) chan_i (
            .capture_mode (ch_capture[g]),
            .cnt          (cnt),
            .reload_val   (reload_val),
            .cmp_val      (cmp_val[g]),
            .cap_edge     (cap_edge[g]),
            .ovf          (ovf),
            .cap_read     (cap_read[g]),
            .flag_now     (status_q[CH_BASE + g]),
            .set_flag     (ch_set[g]),
            .set_ovc      (ch_ovc[g]),
            .clr_flag     (ch_clr[g])
        );
    end

    tsf_gate_fsm gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (slave_en && gated_mode),
        .start_evt  (gate_start),
        .stop_evt   (gate_stop),
        .trig_pulse (gate_trig)
    );

    assign trig_set = (slave_en && !gated_mode && trig_edge) || gate_trig;

    always_comb begin
        set_word = '0;
        clr_word = '0;
        set_word[UPD_BIT] = ovf;
        set_word[TRG_BIT] = trig_set;
        for (int i = 0; i < NUM_CH; i++) begin
            set_word[CH_BASE + i]  = ch_set[i];
            set_word[OVC_BASE + i] = ch_ovc[i];
            clr_word[CH_BASE + i]  = ch_clr[i];
        end
        keep_word = stat_wr ? bus_wdata : '1;
        // hardware sets are merged last so they win over any clear
        status_d  = ((status_q & keep_word & ~clr_word) | set_word) & FLAG_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign irq = |(status_q & irq_en);

endmodule

// File: rtl/tsf_status_chk.sv
module tsf_status_chk #(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_capture,
    input logic [NUM_CH-1:0] cap_edge,
    input logic              ovf,
    input logic              slave_en,
    input logic              gated_mode,
    input logic              trig_edge,
    input logic              bus_rd,
    input logic [SEL_W-1:0]  bus_sel,
    input logic [15:0]       status_q,
    input logic              irq
);

    AST_UPDATE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> status_q[0]); // R11

    AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_capture[0] && cap_edge[0]) |=> status_q[1]); // R5

    AST_OVC_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_capture[0] |=> !$rose(status_q[9])); // R7

    AST_READ_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_capture[0] && cap_edge[0] && bus_rd && bus_sel == SEL_W'(1))
        |=> (status_q[1] && !$rose(status_q[9]))); // R8

    AST_TRIG_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && !gated_mode && trig_edge) |=> status_q[6]); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != 16'h0000)); // R13

endmodule

bind tsf_status_flags tsf_status_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_capture (ch_capture),
    .cap_edge   (cap_edge),
    .ovf        (ovf),
    .slave_en   (slave_en),
    .gated_mode (gated_mode),
    .trig_edge  (trig_edge),
    .bus_rd     (bus_rd),
    .bus_sel    (bus_sel),
    .status_q   (status_q),
    .irq        (irq)
);

// File: tb/tsf_status_flags_tb.sv
`timescale 1ns/1ps
module tsf_status_flags_tb_top;

    typedef struct {
        logic [15:0] st;
        logic        irq;
        string       tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      cnt = 16'd5;
    logic [15:0]      reload_val = 16'd100;
    logic [1:0][15:0] cmp_val;
    logic [1:0]       ch_capture = 2'b00;
    logic [1:0]       cap_edge = 2'b00;
    logic             ovf = 1'b0;
    logic             slave_en = 1'b0;
    logic             gated_mode = 1'b0;
    logic             trig_edge = 1'b0;
    logic             gate_start = 1'b0;
    logic             gate_stop = 1'b0;
    logic             bus_rd = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_sel = 2'd0;
    logic [15:0]      bus_wdata = 16'h0000;
    logic [15:0]      bus_rdata;
    logic [15:0]      irq_en = 16'h0000;
    logic             irq;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    tsf_status_flags dut_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .reload_val(reload_val),
        .cmp_val(cmp_val), .ch_capture(ch_capture), .cap_edge(cap_edge),
        .ovf(ovf), .slave_en(slave_en), .gated_mode(gated_mode),
        .trig_edge(trig_edge), .gate_start(gate_start), .gate_stop(gate_stop),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en), .irq(irq)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (bus_rdata !== e.st || irq !== e.irq) begin
                errors++;
                $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                         e.tag, bus_rdata, irq, e.st, e.irq);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input logic [15:0] st, input logic ir, input string tag);
        exp_t e;
        e.st = st; e.irq = ir; e.tag = tag;
        sb_q.push_back(e);
        step();
    endtask

    task automatic clear_all();
        bus_wr = 1'b1; bus_wdata = 16'h0000; bus_sel = 2'd0;
        step();
        bus_wr = 1'b0;
    endtask

    initial begin
        cmp_val[0] = 16'd30;
        cmp_val[1] = 16'd40;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_st(16'h0000, 1'b0, "R1 reset value");

        // update flag, compare value within reload range
        ovf = 1'b1; step(); ovf = 1'b0;
        expect_st(16'h0001, 1'b0, "R11 R4 overflow sets update only");
        bus_wr = 1'b1; bus_wdata = 16'hFFFF; step(); bus_wr = 1'b0;
        expect_st(16'h0001, 1'b0, "R2 R1 write ones keeps, reserved stay 0");
        bus_wr = 1'b1; bus_wdata = 16'hFFFE; step(); bus_wr = 1'b0;
        expect_st(16'h0000, 1'b0, "R2 write zero clears");

        // compare matches
        cnt = 16'd30; step(); cnt = 16'd5;
        expect_st(16'h0002, 1'b0, "R3 channel 0 match");
        cnt = 16'd40; step(); cnt = 16'd5;
        expect_st(16'h0006, 1'b0, "R3 channel 1 match");
        clear_all();

        // compare above reload
        cmp_val[0] = 16'd150;
        ovf = 1'b1; step(); ovf = 1'b0;
        expect_st(16'h0003, 1'b0, "R4 compare above reload flags at overflow");
        clear_all();
        cmp_val[0] = 16'd30;

        // capture mode on channel 0
        ch_capture = 2'b01;
        cnt = 16'd30; step(); cnt = 16'd5;
        expect_st(16'h0000, 1'b0, "R5 match ignored in capture mode");
        cap_edge = 2'b01; step(); cap_edge = 2'b00;
        expect_st(16'h0002, 1'b0, "R5 capture sets flag");
        cap_edge = 2'b10; step(); cap_edge = 2'b00;
        expect_st(16'h0002, 1'b0, "R5 capture strobe ignored in compare mode");
        cap_edge = 2'b01; step(); cap_edge = 2'b00;
        expect_st(16'h0202, 1'b0, "R7 second capture raises overcapture");
        bus_rd = 1'b1; bus_sel = 2'd1; step(); bus_rd = 1'b0; bus_sel = 2'd0;
        expect_st(16'h0200, 1'b0, "R6 value read clears capture flag");
        clear_all();
        expect_st(16'h0000, 1'b0, "R2 overcapture cleared by write zero");

        // read in compare mode leaves flag
        cnt = 16'd40; step(); cnt = 16'd5;
        bus_rd = 1'b1; bus_sel = 2'd2; step(); bus_rd = 1'b0; bus_sel = 2'd0;
        expect_st(16'h0004, 1'b0, "R6 value read ignored in compare mode");
        clear_all();

        // capture racing a value read
        cap_edge = 2'b01; step(); cap_edge = 2'b00;
        cap_edge = 2'b01; bus_rd = 1'b1; bus_sel = 2'd1;
        step();
        cap_edge = 2'b00; bus_rd = 1'b0; bus_sel = 2'd0;
        expect_st(16'h0002, 1'b0, "R8 capture with read keeps flag, no overcapture");
        clear_all();
        ch_capture = 2'b00;

        // hardware set against software clear
        ovf = 1'b1; bus_wr = 1'b1; bus_wdata = 16'h0000; step();
        ovf = 1'b0; bus_wr = 1'b0;
        expect_st(16'h0001, 1'b0, "R12 set wins over clear");
        clear_all();

        // free-running trigger
        trig_edge = 1'b1; step(); trig_edge = 1'b0;
        expect_st(16'h0000, 1'b0, "R9 trigger ignored with slave disabled");
        slave_en = 1'b1;
        trig_edge = 1'b1; step(); trig_edge = 1'b0;
        expect_st(16'h0040, 1'b0, "R9 trigger edge sets flag");
        clear_all();

        // gated mode
        gated_mode = 1'b1;
        trig_edge = 1'b1; step(); trig_edge = 1'b0;
        expect_st(16'h0000, 1'b0, "R10 trigger edge ignored when gated");
        gate_stop = 1'b1; step(); gate_stop = 1'b0;
        expect_st(16'h0000, 1'b0, "R10 stop while halted ignored");
        gate_start = 1'b1; step(); gate_start = 1'b0;
        expect_st(16'h0040, 1'b0, "R10 start sets trigger");
        clear_all();
        gate_start = 1'b1; step(); gate_start = 1'b0;
        expect_st(16'h0000, 1'b0, "R10 repeated start ignored");
        gate_stop = 1'b1; step(); gate_stop = 1'b0;
        expect_st(16'h0040, 1'b0, "R10 stop sets trigger");
        clear_all();
        slave_en = 1'b0; gated_mode = 1'b0;

        // interrupt masking
        irq_en = 16'h0001;
        ovf = 1'b1; step(); ovf = 1'b0;
        expect_st(16'h0001, 1'b1, "R13 enabled flag raises irq");
        irq_en = 16'h0040; #1;
        expect_st(16'h0001, 1'b0, "R13 disabled flag keeps irq low");
        irq_en = 16'h0001;
        clear_all();
        expect_st(16'h0000, 1'b0, "R13 irq drops after clear");

        step(); step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule